// File: doc/BRIEF.md
# Configurable Multi-Port Register-Array RAM

This block is a small storage array built from flip-flops. Writes are synchronous and reads are combinational. A single parameter picks one of four port arrangements:

- **Single:** one read/write port.
- **Dual:** a read/write port plus one independent read-only port.
- **Simple dual:** one write-only port and one read-only port.
- **Quad:** a read/write port plus three independent read-only ports.

Depth and word width are also parameters.

Every read-only port beyond the primary one is served by its own full copy of the storage. All copies are written together on the same clock edge. The write location always comes from port A's address, and one write strobe vector feeds every copy. Each read output is a pure combinational function of its address and the stored contents. Read outputs that the selected arrangement does not use are held at zero. Storage contents are undefined until written.

Top module: `multiport_lutram`

## Requirements
- R1: On a rising clock edge with `wr_en` high, `din` is stored at the location given by `addr_a`. Any read port addressing that location returns the new word after the edge.
- R2: On a rising edge with `wr_en` low, no location changes, whatever `addr_a` and `din` hold.
- R3: Every live read output follows a change of its address with no clock edge in between.
- R4: If a read address equals `addr_a` while `wr_en` is high, that output shows the old word before the edge and the new word right after it.
- R5: In single mode (MODE=0), `dout_a` reads the location at `addr_a`, and `dout_b`, `dout_c` and `dout_d` are zero.
- R6: In dual mode (MODE=1), `dout_a` reads at `addr_a` and `dout_b` reads at `addr_b`. Port B never chooses the write location, and `dout_c` and `dout_d` are zero.
- R7: In simple-dual mode (MODE=2), `dout_a` is zero and `dout_b` reads at `addr_b` the words written through port A. `dout_c` and `dout_d` are zero.
- R8: In quad mode (MODE=3), `dout_a` reads at `addr_a`, and `dout_b`, `dout_c` and `dout_d` read independently at `addr_b`, `addr_c` and `addr_d`. Every copy holds the same contents.
- R9: Location 0 and location DEPTH-1 are written and read back like any other location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock |
| wr_en | input | 1 | Active-high write enable |
| addr_a | input | $clog2(DEPTH) | Write address; read address of port A |
| din | input | WIDTH | Write data |
| addr_b | input | $clog2(DEPTH) | Read address, port B |
| addr_c | input | $clog2(DEPTH) | Read address, port C |
| addr_d | input | $clog2(DEPTH) | Read address, port D |
| dout_a | output | WIDTH | Read data, port A (zero in simple-dual mode) |
| dout_b | output | WIDTH | Read data, port B (zero in single mode) |
| dout_c | output | WIDTH | Read data, port C (quad mode only) |
| dout_d | output | WIDTH | Read data, port D (quad mode only) |

## Verification
The bench drives all four arrangements side by side and targets several corner cases:

- **Read during write.** A design that registered its reads, or bypassed write data onto the read path, would show the new word too early or too late in the read-during-write cycle.
- **Write at a location another port is reading.** A replica wired to take its write address from its own read port would corrupt the location port B was reading instead of the location addressed by port A.
- **Address-only read changes.** A read path built with a register would leave the output stale after an address change with no clock edge.
- **Idle ports and array ends.** A slip in port-to-copy mapping would put nonzero data on an idle port or show data on the write-only port A. The two ends of the address range catch off-by-one decoding.

// File: rtl/lutram_pkg.sv
package lutram_pkg;

  typedef enum logic [1:0] {
    PM_SINGLE      = 2'd0,
    PM_DUAL        = 2'd1,
    PM_SIMPLE_DUAL = 2'd2,
    PM_QUAD        = 2'd3
  } port_mode_e;

  localparam int unsigned NUM_PORTS = 4;

  // Number of storage copies the arrangement needs.
  function automatic int unsigned bank_count(port_mode_e mode);
    case (mode)
      PM_DUAL: return 2;
      PM_QUAD: return 4;
      default: return 1;
    endcase
  endfunction

  // Which port address (0=A .. 3=D) feeds the read side of copy k.
  function automatic int unsigned bank_read_source(port_mode_e mode, int unsigned k);
    if (mode == PM_SIMPLE_DUAL && k == 0) return 1;
    return k;
  endfunction

  // Which copy drives read output p; -1 means the output is tied to zero.
  function automatic int port_bank(port_mode_e mode, int unsigned p);
    case (mode)
      PM_SINGLE:      return (p == 0) ? 0 : -1;
      PM_DUAL:        return (p < 2) ? int'(p) : -1;
      PM_SIMPLE_DUAL: return (p == 1) ? 0 : -1;
      default:        return int'(p);
    endcase
  endfunction

endpackage

// File: rtl/lutram_wr_decode.sv
module lutram_wr_decode #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output logic [DEPTH-1:0] wr_sel
);

  // One-hot strobe, all zero when no write is requested.
  always_comb begin
    wr_sel = '0;
    if (wr_en) wr_sel[wr_addr] = 1'b1;
  end

endmodule

// File: rtl/lutram_bank.sv
module lutram_bank #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 4,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [DEPTH-1:0] wr_sel,
  input  logic [WIDTH-1:0] din,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (wr_sel[i]) mem[i] <= din;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/multiport_lutram.sv
module multiport_lutram
  import lutram_pkg::*;
#(
  parameter port_mode_e  MODE  = PM_QUAD,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 4,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr_a,
  input  logic [WIDTH-1:0] din,
  input  logic [AW-1:0]    addr_b,
  input  logic [AW-1:0]    addr_c,
  input  logic [AW-1:0]    addr_d,
  output logic [WIDTH-1:0] dout_a,
  output logic [WIDTH-1:0] dout_b,
  output logic [WIDTH-1:0] dout_c,
  output logic [WIDTH-1:0] dout_d
);

  localparam int unsigned NBANK = bank_count(MODE);

  // Shared write strobe: every copy sees this same vector.
  logic [DEPTH-1:0] wr_sel;
  logic [AW-1:0]    port_addr [NUM_PORTS];
  logic [WIDTH-1:0] bank_data [NBANK];
  logic [WIDTH-1:0] port_data [NUM_PORTS];

  assign port_addr[0] = addr_a;
  assign port_addr[1] = addr_b;
  assign port_addr[2] = addr_c;
  assign port_addr[3] = addr_d;

  lutram_wr_decode #(.DEPTH(DEPTH)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (addr_a),
    .wr_sel  (wr_sel)
  );

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    lutram_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
      .clk     (clk),
      .wr_sel  (wr_sel),
      .din     (din),
      .rd_addr (port_addr[bank_read_source(MODE, k)]),
      .rd_data (bank_data[k])
    );
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    if (port_bank(MODE, p) >= 0) begin : g_live
      assign port_data[p] = bank_data[port_bank(MODE, p)];
    end else begin : g_idle
      assign port_data[p] = '0;
    end
  end

  assign dout_a = port_data[0];
  assign dout_b = port_data[1];
  assign dout_c = port_data[2];
  assign dout_d = port_data[3];

endmodule

// File: rtl/lutram_checker.sv
module lutram_checker
  import lutram_pkg::*;
#(
  parameter port_mode_e  MODE  = PM_QUAD,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 4,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             wr_en,
  input logic [AW-1:0]    addr_a,
  input logic [WIDTH-1:0] din,
  input logic [AW-1:0]    addr_b,
  input logic [AW-1:0]    addr_c,
  input logic [AW-1:0]    addr_d,
  input logic [WIDTH-1:0] dout_a,
  input logic [WIDTH-1:0] dout_b,
  input logic [WIDTH-1:0] dout_c,
  input logic [WIDTH-1:0] dout_d,
  input logic [DEPTH-1:0] wr_sel
);

  logic primed = 1'b0;
  logic [DEPTH-1:0] written = '0;

  always_ff @(posedge clk) begin
    primed <= 1'b1;
    if (wr_en) written[addr_a] <= 1'b1;
  end

  // R1: the shared strobe marks exactly the addressed word on a write
  p_strobe_r1: assert property (@(posedge clk) disable iff (!primed)
    wr_en |-> ($countones(wr_sel) == 1 && wr_sel[addr_a]));

  // R2: no strobe without the enable
  p_no_strobe_r2: assert property (@(posedge clk) disable iff (!primed)
    !wr_en |-> $onehot0(wr_sel) && (wr_sel == '0));

  if (MODE != PM_SIMPLE_DUAL) begin : g_a
    p_hold_r2: assert property (@(posedge clk) disable iff (!primed)
      !wr_en |=> ($stable(addr_a) -> $stable(dout_a)));
  end else begin : g_a_idle
    p_a_zero_r7: assert property (@(posedge clk) disable iff (!primed)
      dout_a == '0);
  end

  if (MODE != PM_SINGLE) begin : g_b
    p_write_lands_r4: assert property (@(posedge clk) disable iff (!primed)
      (wr_en && addr_b == addr_a) |=> ($stable(addr_b) -> dout_b == $past(din)));
  end else begin : g_b_idle
    p_b_zero_r5: assert property (@(posedge clk) disable iff (!primed)
      dout_b == '0);
  end

  if (MODE == PM_QUAD) begin : g_q
    p_replicas_agree_r8: assert property (@(posedge clk) disable iff (!primed)
      (addr_b == addr_c && addr_c == addr_d && written[addr_b]) |->
        (dout_b == dout_c && dout_c == dout_d));
  end else begin : g_cd_idle
    p_cd_zero_r6: assert property (@(posedge clk) disable iff (!primed)
      dout_c == '0 && dout_d == '0);
  end

endmodule

bind multiport_lutram lutram_checker #(.MODE(MODE), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .wr_en(wr_en), .addr_a(addr_a), .din(din),
  .addr_b(addr_b), .addr_c(addr_c), .addr_d(addr_d),
  .dout_a(dout_a), .dout_b(dout_b), .dout_c(dout_c), .dout_d(dout_d),
  .wr_sel(wr_sel)
);

// File: tb/tb_multiport_lutram.sv
`timescale 1ns/1ps
module tb_multiport_lutram;
  import lutram_pkg::*;

  localparam int unsigned DEPTH = 32;
  localparam int unsigned WIDTH = 4;
  localparam int unsigned AW = $clog2(DEPTH);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             wr_en = 1'b0;
  logic [AW-1:0]    addr_a = '0, addr_b = '0, addr_c = '0, addr_d = '0;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] o [16];
  logic [WIDTH-1:0] ref_mem [DEPTH];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  multiport_lutram #(.MODE(PM_QUAD), .DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk(clk), .wr_en(wr_en), .addr_a(addr_a), .din(din),
    .addr_b(addr_b), .addr_c(addr_c), .addr_d(addr_d),
    .dout_a(o[12]), .dout_b(o[13]), .dout_c(o[14]), .dout_d(o[15]));
  multiport_lutram #(.MODE(PM_SINGLE), .DEPTH(DEPTH), .WIDTH(WIDTH)) dut_single (
    .clk(clk), .wr_en(wr_en), .addr_a(addr_a), .din(din),
    .addr_b(addr_b), .addr_c(addr_c), .addr_d(addr_d),
    .dout_a(o[0]), .dout_b(o[1]), .dout_c(o[2]), .dout_d(o[3]));
  multiport_lutram #(.MODE(PM_DUAL), .DEPTH(DEPTH), .WIDTH(WIDTH)) dut_dual (
    .clk(clk), .wr_en(wr_en), .addr_a(addr_a), .din(din),
    .addr_b(addr_b), .addr_c(addr_c), .addr_d(addr_d),
    .dout_a(o[4]), .dout_b(o[5]), .dout_c(o[6]), .dout_d(o[7]));
  multiport_lutram #(.MODE(PM_SIMPLE_DUAL), .DEPTH(DEPTH), .WIDTH(WIDTH)) dut_sdp (
    .clk(clk), .wr_en(wr_en), .addr_a(addr_a), .din(din),
    .addr_b(addr_b), .addr_c(addr_c), .addr_d(addr_d),
    .dout_a(o[8]), .dout_b(o[9]), .dout_c(o[10]), .dout_d(o[11]));

  // Output index = 4*instance + port, instances: single, dual, simple-dual, quad.
  typedef struct {
    int               idx;
    logic [WIDTH-1:0] exp;
    string            tag;
  } item_t;

  item_t sb_q[$];
  event  chk_ev;

  function automatic logic [WIDTH-1:0] pattern(int i);
    return WIDTH'((i * 5 + 3) % (1 << WIDTH));
  endfunction

  task automatic push(int idx, logic [WIDTH-1:0] exp, string tag);
    item_t it;
    it.idx = idx; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic flush();
    -> chk_ev;
    #0.1;
  endtask

  // Monitor: pops expectations and compares against the live outputs.
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (o[it.idx] !== it.exp) begin
          errors++;
          $display("FAIL %s: output %0d actual=%h expected=%h", it.tag, it.idx, o[it.idx], it.exp);
        end
      end
    end
  end

  task automatic write_word(logic [AW-1:0] a, logic [WIDTH-1:0] d);
    @(negedge clk);
    addr_a = a; din = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    ref_mem[a] = d;
  endtask

  task automatic set_reads(logic [AW-1:0] a, logic [AW-1:0] b, logic [AW-1:0] c, logic [AW-1:0] d);
    addr_a = a; addr_b = b; addr_c = c; addr_d = d;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    for (int i = 0; i < int'(DEPTH); i++) write_word(AW'(i), pattern(i));

    // R1 / R9: written words read back, ends of the array included
    set_reads(AW'(0), AW'(DEPTH-1), AW'(9), AW'(17));
    push(12, ref_mem[0], "R9"); push(13, ref_mem[DEPTH-1], "R9");
    push(14, ref_mem[9], "R1"); push(15, ref_mem[17], "R1");
    flush();
    write_word(AW'(DEPTH-1), 4'hA); write_word(AW'(0), 4'h5);
    set_reads(AW'(DEPTH-1), AW'(0), AW'(0), AW'(DEPTH-1));
    push(12, 4'hA, "R9"); push(13, 4'h5, "R9"); push(14, 4'h5, "R9"); push(15, 4'hA, "R9");
    flush();

    // R2: edge with enable low changes nothing
    @(negedge clk);
    addr_a = AW'(7); din = ~ref_mem[7]; wr_en = 1'b0;
    @(negedge clk);
    set_reads(AW'(7), AW'(7), AW'(7), AW'(7));
    push(12, ref_mem[7], "R2"); push(13, ref_mem[7], "R2"); push(0, ref_mem[7], "R2");
    flush();

    // R3: address change alone updates the read
    set_reads(AW'(3), AW'(4), AW'(5), AW'(6));
    push(13, ref_mem[4], "R3");
    flush();
    set_reads(AW'(3), AW'(20), AW'(21), AW'(22));
    push(13, ref_mem[20], "R3"); push(14, ref_mem[21], "R3"); push(15, ref_mem[22], "R3");
    flush();

    // R4: read during write shows old then new
    @(negedge clk);
    addr_a = AW'(5); addr_b = AW'(5); din = ~ref_mem[5]; wr_en = 1'b1;
    #1;
    push(12, ref_mem[5], "R4"); push(13, ref_mem[5], "R4"); push(9, ref_mem[5], "R4");
    flush();
    @(posedge clk);
    #1;
    ref_mem[5] = din;
    push(12, ref_mem[5], "R4"); push(13, ref_mem[5], "R4"); push(9, ref_mem[5], "R4");
    flush();
    @(negedge clk);
    wr_en = 1'b0;

    // R5: single mode
    set_reads(AW'(12), AW'(13), AW'(14), AW'(15));
    push(0, ref_mem[12], "R5"); push(1, '0, "R5"); push(2, '0, "R5"); push(3, '0, "R5");
    flush();

    // R6: dual mode, port B never picks the write location
    @(negedge clk);
    addr_b = AW'(11); addr_a = AW'(10); din = ~ref_mem[10]; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ref_mem[10] = din;
    #1;
    push(5, ref_mem[11], "R6"); push(4, ref_mem[10], "R6");
    push(6, '0, "R6"); push(7, '0, "R6");
    flush();
    set_reads(AW'(11), AW'(10), AW'(0), AW'(0));
    push(5, ref_mem[10], "R6"); push(4, ref_mem[11], "R6");
    flush();

    // R7: simple-dual mode
    set_reads(AW'(2), AW'(19), AW'(1), AW'(1));
    push(8, '0, "R7"); push(9, ref_mem[19], "R7"); push(10, '0, "R7"); push(11, '0, "R7");
    flush();

    // R8: quad mode, three independent reads
    set_reads(AW'(24), AW'(25), AW'(26), AW'(27));
    push(12, ref_mem[24], "R8"); push(13, ref_mem[25], "R8");
    push(14, ref_mem[26], "R8"); push(15, ref_mem[27], "R8");
    flush();
    set_reads(AW'(30), AW'(30), AW'(30), AW'(30));
    push(13, ref_mem[30], "R8"); push(14, ref_mem[30], "R8"); push(15, ref_mem[30], "R8");
    flush();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule